// File: doc/BRIEF.md
# Overflow and End-of-Message Interrupt Controller

This block keeps the two status flags of a record/playback engine and drives its shared interrupt line. An overflow flag sets when the engine hits the end of storage, whether it is recording or playing back. An end-of-message flag sets only during playback, when the engine enters a storage location whose marker bit is set. Each row of storage has eight marker slots, supplied by the caller as an 8-bit mask for the current row.

While either flag is set, the block asks the open-drain pad to pull the interrupt line low. An external pull-up brings the line high again. The flags clear when the host begins its next serial transaction, which the block sees as a falling edge on chip-select. At that same edge the block copies the flag values into a snapshot. A read-interrupt command later in the transaction loads that snapshot into the read-back output, so the host still sees why it was interrupted.

Whenever a flag sets, the block sends the engine a one-cycle stop request. It then ignores any further conditions until the current operation ends. The next operation re-arms it, so every operation that ends on one of these conditions raises the interrupt again.

Top module: `msg_irq_ctrl`

## Requirements
- R1: After reset, `ovfFlag`, `eomFlag`, `irqPullLow`, `stopReq` and `rdFlags` are all 0.
- R2: While `opActive` is 1, in either record or playback, a rising edge on `endOfMem` sets `ovfFlag` at the next clock edge.
- R3: During playback (`isPlayback`=1, `opActive`=1), entering a location sets `eomFlag` at that clock edge when `eomMask[posIdx]` is 1. Mask bit i belongs to position i. Entering a location means the first active cycle of an operation, or a change of `rowIdx` or `posIdx`. A mask change with the location held does not count as entering.
- R4: During record (`isPlayback`=0), or at positions whose mask bit is 0, `eomFlag` stays 0.
- R5: `irqPullLow` is 1 exactly when `ovfFlag` or `eomFlag` is 1. It holds until the flags are cleared.
- R6: A clock edge that sees `csN` low after it was high clears both flags. Holding `csN` low, and a rising `csN`, clear nothing.
- R7: At a chip-select falling edge the flags are copied into a snapshot before they clear. A `rintStrobe` cycle loads that snapshot into `rdFlags` at the next edge, with bit 1 = overflow and bit 0 = end-of-message. Otherwise `rdFlags` holds.
- R8: `stopReq` is high for exactly one cycle, the cycle in which a newly set flag first shows.
- R9: An overflow and an end-of-message in the same cycle set both flags.
- R10: After a stop request, further overflow or end-of-message conditions are ignored until `opActive` goes to 0. The next operation is armed again.
- R11: A flag that is set in the same cycle as a chip-select falling edge ends up set, because setting takes priority over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| opActive | input | 1 | A record or playback operation is running |
| isPlayback | input | 1 | 1 = playback, 0 = record |
| rowIdx | input | ROW_W | Current storage row |
| posIdx | input | log2(MARKS) | Marker slot within the row |
| eomMask | input | MARKS | Marker bits of the current row |
| endOfMem | input | 1 | End of storage reached |
| csN | input | 1 | Serial chip-select, active low |
| rintStrobe | input | 1 | Read-interrupt command decoded |
| irqPullLow | output | 1 | Pull-low enable for the open-drain interrupt pad |
| ovfFlag | output | 1 | Overflow flag |
| eomFlag | output | 1 | End-of-message flag |
| stopReq | output | 1 | One-cycle request to end the operation |
| rdFlags | output | 2 | Read-back status {overflow, end-of-message} |

## Verification
The flag logic is tried with several input patterns:
- A record pass over a fully marked row separates position-based detection from mode gating.
- A playback pass that walks through unmarked slots into a marked one checks that marker bit i belongs to slot i.
- A row change at a fixed slot, and a mask change at a fixed location, together show that only entering a location counts.
- Overflow and end-of-message arriving together, and a set coinciding with a chip-select fall, probe the priorities.
- Chip-select held low and then released checks that only the falling edge clears.
- Read-back after each transaction shows the snapshot taken before the clear.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  // Conditions seen by the datapath, handed to the control
  typedef struct packed {
    logic ovfHit;
    logic eomHit;
    logic csFall;
    logic rint;
  } flagEvt_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic setOvf;
    logic setEom;
    logic clrFlags;
    logic takeSnap;
    logic loadRd;
  } flagCmd_t;

  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_HALTED = 1'b1
  } ctlState_t;

  localparam int FLAG_N = 2;  // index 1 = overflow, index 0 = end-of-message

endpackage

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int MARKS = 8,
  localparam int POS_W = $clog2(MARKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opActive,
  input  logic             isPlayback,
  input  logic [ROW_W-1:0] rowIdx,
  input  logic [POS_W-1:0] posIdx,
  input  logic [MARKS-1:0] eomMask,
  input  logic             endOfMem,
  input  logic             csN,
  input  logic             rintStrobe,
  input  flagCmd_t         cmd,
  output flagEvt_t         evt,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] rdFlags
);

  logic [ROW_W-1:0]  lastRow;
  logic [POS_W-1:0]  lastPos;
  logic              wasActive;
  logic              endPrev;
  logic              csPrev;
  logic              newLoc;
  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] snapFlags;

  // History of the inputs used for edge and location-change detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRow   <= '0;
      lastPos   <= '0;
      wasActive <= 1'b0;
      endPrev   <= 1'b0;
      csPrev    <= 1'b1;
    end else begin
      lastRow   <= rowIdx;
      lastPos   <= posIdx;
      wasActive <= opActive;
      endPrev   <= endOfMem;
      csPrev    <= csN;
    end
  end

  always_comb begin
    newLoc     = opActive && (!wasActive || (rowIdx != lastRow) || (posIdx != lastPos));
    evt.eomHit = newLoc && isPlayback && eomMask[posIdx];
    evt.ovfHit = opActive && endOfMem && (!endPrev || !wasActive);
    evt.csFall = csPrev && !csN;
    evt.rint   = rintStrobe;
  end

  assign setVec = {cmd.setOvf, cmd.setEom};

  // One set-over-clear cell per flag
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[i] <= 1'b0;
      end else if (setVec[i]) begin
        flags[i] <= 1'b1;
      end else if (cmd.clrFlags) begin
        flags[i] <= 1'b0;
      end
    end
  end

  // Snapshot at transaction start, read-back on command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapFlags <= '0;
      rdFlags   <= '0;
    end else begin
      if (cmd.takeSnap) snapFlags <= flags;
      if (cmd.loadRd)   rdFlags   <= snapFlags;
    end
  end

endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opActive,
  input  flagEvt_t evt,
  output flagCmd_t cmd,
  output logic     stopReq
);

  ctlState_t state, stateNext;
  logic      stopNext;

  always_comb begin
    cmd          = '0;
    stateNext    = state;
    stopNext     = 1'b0;
    cmd.clrFlags = evt.csFall;
    cmd.takeSnap = evt.csFall;
    cmd.loadRd   = evt.rint;
    case (state)
      ST_ARMED: begin
        if (evt.ovfHit || evt.eomHit) begin
          cmd.setOvf = evt.ovfHit;
          cmd.setEom = evt.eomHit;
          stopNext   = 1'b1;
          stateNext  = ST_HALTED;
        end
      end
      ST_HALTED: begin
        if (!opActive) stateNext = ST_ARMED;
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_ARMED;
      stopReq <= 1'b0;
    end else begin
      state   <= stateNext;
      stopReq <= stopNext;
    end
  end

endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl
  import irq_flag_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int MARKS = 8,
  localparam int POS_W = $clog2(MARKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opActive,
  input  logic             isPlayback,
  input  logic [ROW_W-1:0] rowIdx,
  input  logic [POS_W-1:0] posIdx,
  input  logic [MARKS-1:0] eomMask,
  input  logic             endOfMem,
  input  logic             csN,
  input  logic             rintStrobe,
  output logic             irqPullLow,
  output logic             ovfFlag,
  output logic             eomFlag,
  output logic             stopReq,
  output logic [1:0]       rdFlags
);

  flagEvt_t          evt;
  flagCmd_t          cmd;
  logic [FLAG_N-1:0] flags;

  irq_flag_dp #(.ROW_W(ROW_W), .MARKS(MARKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .opActive   (opActive),
    .isPlayback (isPlayback),
    .rowIdx     (rowIdx),
    .posIdx     (posIdx),
    .eomMask    (eomMask),
    .endOfMem   (endOfMem),
    .csN        (csN),
    .rintStrobe (rintStrobe),
    .cmd        (cmd),
    .evt        (evt),
    .flags      (flags),
    .rdFlags    (rdFlags)
  );

  irq_flag_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .opActive (opActive),
    .evt      (evt),
    .cmd      (cmd),
    .stopReq  (stopReq)
  );

  assign ovfFlag    = flags[1];
  assign eomFlag    = flags[0];
  assign irqPullLow = |flags;

endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk (
  input logic clk,
  input logic rstN,
  input logic opActive,
  input logic isPlayback,
  input logic endOfMem,
  input logic csN,
  input logic irqPullLow,
  input logic ovfFlag,
  input logic eomFlag,
  input logic stopReq
);

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !stopReq);  // R8

  AST_STOP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> irqPullLow);  // R5

  AST_EOM_PLAYBACK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eomFlag) |-> $past(isPlayback && opActive));  // R4

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(endOfMem && opActive));  // R2

  AST_CLEAR_ON_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> (!irqPullLow || stopReq));  // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqPullLow && csN) |=> irqPullLow);  // R5

endmodule

bind msg_irq_ctrl irq_flag_chk u_chk (.*);

// File: tb/msg_irq_ctrl_tb.sv
module msg_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opActive = 1'b0;
  logic       isPlayback = 1'b0;
  logic [8:0] rowIdx = '0;
  logic [2:0] posIdx = '0;
  logic [7:0] eomMask = '0;
  logic       endOfMem = 1'b0;
  logic       csN = 1'b1;
  logic       rintStrobe = 1'b0;
  logic       irqPullLow, ovfFlag, eomFlag, stopReq;
  logic [1:0] rdFlags;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  int         qCyc[$];
  logic [4:0] qVal[$];
  string      qTag[$];

  always #4 clk = ~clk;  // 125 MHz

  msg_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .opActive(opActive), .isPlayback(isPlayback),
    .rowIdx(rowIdx), .posIdx(posIdx), .eomMask(eomMask), .endOfMem(endOfMem),
    .csN(csN), .rintStrobe(rintStrobe), .irqPullLow(irqPullLow),
    .ovfFlag(ovfFlag), .eomFlag(eomFlag), .stopReq(stopReq), .rdFlags(rdFlags)
  );

  // Driver: inputs are already set; queue the expectation for the next edge
  task automatic tick(input logic eOvf, input logic eEom, input logic eStop,
                      input logic [1:0] eRd, input string tag);
    qCyc.push_back(cyc + 1);
    qVal.push_back({eOvf, eEom, eStop, eRd});
    qTag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: sample after each edge and compare with the queue head
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      while (qCyc.size() > 0 && qCyc[0] == cyc) begin
        logic [4:0] e;
        logic [5:0] act, expv;
        string t;
        e = qVal.pop_front();
        t = qTag.pop_front();
        void'(qCyc.pop_front());
        expv = {e[4] | e[3], e};  // R5: irq follows either flag
        act  = {irqPullLow, ovfFlag, eomFlag, stopReq, rdFlags};
        checks++;
        if (act !== expv) begin
          fails++;
          $display("FAIL %s cyc %0d {irq,ovf,eom,stop,rd} actual %b expected %b",
                   t, cyc, act, expv);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(0, 0, 0, 2'b00, "R1 in reset");
    tick(0, 0, 0, 2'b00, "R1 in reset");
    rstN = 1'b1;
    tick(0, 0, 0, 2'b00, "R1 after release");

    // Record over a fully marked row
    opActive = 1; isPlayback = 0; rowIdx = 5; posIdx = 2; eomMask = 8'hFF;
    tick(0, 0, 0, 2'b00, "R4 record marked slot");
    posIdx = 3;
    tick(0, 0, 0, 2'b00, "R4 record next slot");
    endOfMem = 1;
    tick(1, 0, 1, 2'b00, "R2 R8 overflow in record");
    tick(1, 0, 0, 2'b00, "R8 stop one cycle");
    csN = 0;
    tick(0, 0, 0, 2'b00, "R6 clear on select fall");
    tick(0, 0, 0, 2'b00, "R6 select held low");
    rintStrobe = 1;
    tick(0, 0, 0, 2'b10, "R7 readback overflow");
    rintStrobe = 0; csN = 1;
    tick(0, 0, 0, 2'b10, "R7 readback holds");

    // Halted: new overflow edge ignored
    endOfMem = 0;
    tick(0, 0, 0, 2'b10, "R10 halted");
    endOfMem = 1;
    tick(0, 0, 0, 2'b10, "R10 overflow ignored after stop");
    opActive = 0; endOfMem = 0;
    tick(0, 0, 0, 2'b10, "R10 operation ends");

    // Playback walking into marked slot 3
    opActive = 1; isPlayback = 1; rowIdx = 7; posIdx = 1; eomMask = 8'b0000_1000;
    tick(0, 0, 0, 2'b10, "R4 unmarked slot 1");
    posIdx = 2;
    tick(0, 0, 0, 2'b10, "R4 unmarked slot 2");
    posIdx = 3;
    tick(0, 1, 1, 2'b10, "R3 R8 marked slot 3");
    tick(0, 1, 0, 2'b10, "R5 irq held");

    // Set and select fall in the same cycle
    opActive = 0;
    tick(0, 1, 0, 2'b10, "R5 held after op end");
    opActive = 1; rowIdx = 8; posIdx = 0; eomMask = 8'b0000_0001; csN = 0;
    tick(0, 1, 1, 2'b10, "R11 set wins over clear");
    csN = 1;
    tick(0, 1, 0, 2'b10, "R6 rise clears nothing");
    rintStrobe = 1;
    tick(0, 1, 0, 2'b01, "R7 snapshot before clear");
    rintStrobe = 0;

    // Both conditions together
    opActive = 0;
    tick(0, 1, 0, 2'b01, "R10 op end");
    csN = 0;
    tick(0, 0, 0, 2'b01, "R6 clear eom");
    csN = 1;
    tick(0, 0, 0, 2'b01, "R6 idle");
    opActive = 1; isPlayback = 1; rowIdx = 9; posIdx = 4; eomMask = 8'h10; endOfMem = 1;
    tick(1, 1, 1, 2'b01, "R9 both flags");
    tick(1, 1, 0, 2'b01, "R9 both held");
    csN = 0;
    tick(0, 0, 0, 2'b01, "R6 clear both");
    rintStrobe = 1;
    tick(0, 0, 0, 2'b11, "R7 readback both");
    rintStrobe = 0; opActive = 0; endOfMem = 0;
    tick(0, 0, 0, 2'b11, "R7 hold");

    // Overflow while select held low, then released
    opActive = 1; isPlayback = 0; endOfMem = 1;
    tick(1, 0, 1, 2'b11, "R2 overflow with select low");
    tick(1, 0, 0, 2'b11, "R6 held low no clear");
    csN = 1;
    tick(1, 0, 0, 2'b11, "R6 rising no clear");

    // Row change at fixed slot versus mask change
    opActive = 0; endOfMem = 0;
    tick(1, 0, 0, 2'b11, "R5 held");
    csN = 0;
    tick(0, 0, 0, 2'b11, "R6 clear");
    csN = 1;
    opActive = 1; isPlayback = 1; rowIdx = 10; posIdx = 6; eomMask = 8'h00;
    tick(0, 0, 0, 2'b11, "R4 unmarked entry");
    eomMask = 8'h40;
    tick(0, 0, 0, 2'b11, "R3 mask change is not entry");
    rowIdx = 11;
    tick(0, 1, 1, 2'b11, "R3 row change enters marked slot 6");
    opActive = 0;
    tick(0, 1, 0, 2'b11, "R8 stop drops");

    repeat (3) @(negedge clk);
    if (qCyc.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual %0d pending expected 0", qCyc.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule